// File: doc/BRIEF.md
# Successor Super-Trace and Core Choice Predictor

This block sits beside the switching controller of a two-core (big out-of-order, little in-order) cluster. At every super-trace boundary it receives the identifier of the super-trace that just finished together with a few low bits of the head address of the code about to run. It returns the identifier of the super-trace most likely to run next, and a flag that says whether that code should run on the big core or on the little core.

Each of the 2^ID_W table rows belongs to one super-trace. A row keeps two candidate successors. Each candidate has its own identifier, a short head-address tag and a confidence counter. The row also keeps one shared core-choice counter. The tag picks between the two candidates.

When a super-trace completes, the controller trains its row with two facts: the successor that really followed it, and whether the measured performance loss stayed under the current threshold. The candidates are then reinforced, demoted or replaced according to their confidence, and the core counter is moved. How the threshold is formed and how performance is estimated lie outside this block.

Top module: `stp_predictor`

## Requirements
- R1: After reset `pred_valid` and `pred_big` are 0 and `pred_id` is 0. Every row starts with both candidates holding identifier 0, tag 0 and confidence 0, and with the core counter at 2 (weakly big), so the first lookup of any row reports identifier 0 and big.
- R2: A lookup presented with `lk_valid` high is answered in the next cycle with `pred_valid` high, and `pred_id` and `pred_big` belong to that row. A cycle without `lk_valid` gives `pred_valid` low in the next cycle.
- R3: When exactly one candidate's tag equals the presented head tag, that candidate's identifier is predicted.
- R4: When both tags match or neither matches, the candidate with the higher confidence is predicted, and a tie goes to candidate 0.
- R5: In training, the prediction is recomputed with the trained tag (the rules of R3 and R4). If the chosen candidate's identifier equals the actual successor, that candidate's confidence rises by one and saturates at 3.
- R6: On a wrong prediction the weaker candidate is examined: the one with strictly lower confidence, or candidate 1 on a tie. If its confidence is 0, it is overwritten with the actual successor identifier, the trained tag and confidence 1.
- R7: On a wrong prediction whose weaker candidate has non-zero confidence, that confidence drops by one. Its identifier and tag are kept, and the other candidate is untouched.
- R8: Every training step moves the row's 2-bit core counter down by one when `tr_below` is 1 and up by one otherwise, saturating at 0 and 3. `pred_big` is the counter's top bit (1 means big, 0 means little).
- R9: If a training update and a lookup address the same row in the same cycle, the lookup answers with the row as updated in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request at a super-trace boundary |
| lk_id | input | ID_W | Identifier of the super-trace just finished (row to read) |
| lk_tag | input | TAG_W | Low head-address bits of the next code, byte offset removed |
| tr_valid | input | 1 | Training request for one row |
| tr_id | input | ID_W | Row to train |
| tr_succ_id | input | ID_W | Successor identifier that really followed |
| tr_succ_tag | input | TAG_W | Head tag of that successor |
| tr_below | input | 1 | 1 when the observed loss was under the threshold |
| pred_valid | output | 1 | Prediction valid, one cycle after the lookup |
| pred_id | output | ID_W | Predicted successor identifier |
| pred_big | output | 1 | 1 selects the big core, 0 the little core |

## Verification
A corrupted confidence counter shows up only indirectly. It decides which candidate wins when no tag or both tags match, and which candidate gets evicted. A wrong value therefore appears at `pred_id` on the first lookup of that row with a non-matching tag, or after the next wrong-prediction training step. A counter that wraps instead of saturating shows up after one more step, because the weaker candidate is then replaced instead of kept. A core counter that wraps at either end flips `pred_big` on the very next lookup of that row. A missing bypass is visible in the same cycle, as a stale answer to the colliding lookup.

// File: rtl/stp_pkg.sv
package stp_pkg;
   typedef enum logic {
      CORE_LITTLE = 1'b0,
      CORE_BIG    = 1'b1
   } core_e;

   localparam int unsigned STP_SLOTS = 2;
endpackage

// File: rtl/stp_slot_pick.sv
module stp_slot_pick #(
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned CONF_W = 2
) (
   input  logic [1:0][TAG_W-1:0]  slot_tag,
   input  logic [1:0][CONF_W-1:0] slot_conf,
   input  logic [TAG_W-1:0]       key,
   output logic                   pick
);
   logic [1:0] hit;

   for (genvar s = 0; s < 2; s++) begin : g_hit
      assign hit[s] = (slot_tag[s] == key);
   end

   always_comb begin
      unique case (hit)
         2'b01:   pick = 1'b0;
         2'b10:   pick = 1'b1;
         default: pick = (slot_conf[1] > slot_conf[0]);
      endcase
   end
endmodule

// File: rtl/stp_entry_update.sv
module stp_entry_update #(
   parameter int unsigned ID_W   = 9,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned CONF_W = 2,
   parameter int unsigned BE_W   = 2
) (
   input  logic [1:0][ID_W-1:0]   old_id,
   input  logic [1:0][TAG_W-1:0]  old_tag,
   input  logic [1:0][CONF_W-1:0] old_conf,
   input  logic [BE_W-1:0]        old_be,
   input  logic [ID_W-1:0]        act_id,
   input  logic [TAG_W-1:0]       act_tag,
   input  logic                   below,
   output logic [1:0][ID_W-1:0]   new_id,
   output logic [1:0][TAG_W-1:0]  new_tag,
   output logic [1:0][CONF_W-1:0] new_conf,
   output logic [BE_W-1:0]        new_be
);
   localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};
   localparam logic [BE_W-1:0]   BE_MAX   = {BE_W{1'b1}};

   logic pick;
   logic victim;
   logic correct;

   stp_slot_pick #(.TAG_W(TAG_W), .CONF_W(CONF_W)) i_pick (
      .slot_tag  (old_tag),
      .slot_conf (old_conf),
      .key       (act_tag),
      .pick      (pick)
   );

   assign correct = (old_id[pick] == act_id);
   assign victim  = !(old_conf[0] < old_conf[1]);

   always_comb begin
      new_id   = old_id;
      new_tag  = old_tag;
      new_conf = old_conf;
      if (correct) begin
         if (old_conf[pick] != CONF_MAX)
            new_conf[pick] = old_conf[pick] + CONF_W'(1);
      end else if (old_conf[victim] == '0) begin
         new_id[victim]   = act_id;
         new_tag[victim]  = act_tag;
         new_conf[victim] = CONF_W'(1);
      end else begin
         new_conf[victim] = old_conf[victim] - CONF_W'(1);
      end
   end

   always_comb begin
      new_be = old_be;
      if (below) begin
         if (old_be != '0) new_be = old_be - BE_W'(1);
      end else if (old_be != BE_MAX) begin
         new_be = old_be + BE_W'(1);
      end
   end
endmodule

// File: rtl/stp_store.sv
module stp_store #(
   parameter int unsigned IDX_W   = 9,
   parameter int unsigned DATA_W  = 30,
   parameter logic [DATA_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_a_idx,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   output logic [DATA_W-1:0] rd_b_data
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
      end else if (wr_en) begin
         mem[wr_idx] <= wr_data;
      end
   end

   assign rd_a_data = mem[rd_a_idx];
   assign rd_b_data = mem[rd_b_idx];
endmodule

// File: rtl/stp_predictor.sv
module stp_predictor
   import stp_pkg::*;
#(
   parameter int unsigned ID_W   = 9,
   parameter int unsigned TAG_W  = 3,
   parameter int unsigned CONF_W = 2,
   parameter int unsigned BE_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [ID_W-1:0]  lk_id,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic             tr_valid,
   input  logic [ID_W-1:0]  tr_id,
   input  logic [ID_W-1:0]  tr_succ_id,
   input  logic [TAG_W-1:0] tr_succ_tag,
   input  logic             tr_below,
   output logic             pred_valid,
   output logic [ID_W-1:0]  pred_id,
   output logic             pred_big
);
   localparam int unsigned SLOT_W  = ID_W + TAG_W + CONF_W;
   localparam int unsigned ENTRY_W = STP_SLOTS * SLOT_W + BE_W;
   localparam int unsigned BE_LSB  = STP_SLOTS * SLOT_W;
   localparam logic [ENTRY_W-1:0] RST_ENTRY = ENTRY_W'(1) << (ENTRY_W - 1);

   if (BE_W < 2) begin : g_bad_be
      $error("stp_predictor: BE_W must be at least 2");
   end
   if (CONF_W < 2) begin : g_bad_conf
      $error("stp_predictor: CONF_W must be at least 2");
   end
   if (ID_W < 1 || ID_W > 12) begin : g_bad_id
      $error("stp_predictor: ID_W must lie in 1..12");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("stp_predictor: TAG_W must be at least 1");
   end

   logic [ENTRY_W-1:0] tr_rd, lk_rd, wr_data, lk_entry;

   logic [1:0][ID_W-1:0]   tr_old_id,   tr_new_id,   lk_id_v;
   logic [1:0][TAG_W-1:0]  tr_old_tag,  tr_new_tag,  lk_tag_v;
   logic [1:0][CONF_W-1:0] tr_old_conf, tr_new_conf, lk_conf_v;
   logic [BE_W-1:0]        tr_old_be,   tr_new_be,   lk_be;
   logic                   lk_pick;
   core_e                  lk_core;

   stp_store #(.IDX_W(ID_W), .DATA_W(ENTRY_W), .RST_VAL(RST_ENTRY)) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (tr_valid),
      .wr_idx    (tr_id),
      .wr_data   (wr_data),
      .rd_a_idx  (tr_id),
      .rd_a_data (tr_rd),
      .rd_b_idx  (lk_id),
      .rd_b_data (lk_rd)
   );

   // update wins a same-row collision; the lookup sees the new row
   assign lk_entry = (tr_valid && (tr_id == lk_id)) ? wr_data : lk_rd;

   for (genvar s = 0; s < STP_SLOTS; s++) begin : g_slot
      localparam int unsigned B = s * SLOT_W;
      assign tr_old_conf[s] = tr_rd[B +: CONF_W];
      assign tr_old_tag[s]  = tr_rd[B + CONF_W +: TAG_W];
      assign tr_old_id[s]   = tr_rd[B + CONF_W + TAG_W +: ID_W];
      assign lk_conf_v[s]   = lk_entry[B +: CONF_W];
      assign lk_tag_v[s]    = lk_entry[B + CONF_W +: TAG_W];
      assign lk_id_v[s]     = lk_entry[B + CONF_W + TAG_W +: ID_W];
      assign wr_data[B +: SLOT_W] = {tr_new_id[s], tr_new_tag[s], tr_new_conf[s]};
   end
   assign tr_old_be = tr_rd[BE_LSB +: BE_W];
   assign lk_be     = lk_entry[BE_LSB +: BE_W];
   assign wr_data[BE_LSB +: BE_W] = tr_new_be;

   stp_entry_update #(.ID_W(ID_W), .TAG_W(TAG_W), .CONF_W(CONF_W), .BE_W(BE_W)) i_upd (
      .old_id   (tr_old_id),
      .old_tag  (tr_old_tag),
      .old_conf (tr_old_conf),
      .old_be   (tr_old_be),
      .act_id   (tr_succ_id),
      .act_tag  (tr_succ_tag),
      .below    (tr_below),
      .new_id   (tr_new_id),
      .new_tag  (tr_new_tag),
      .new_conf (tr_new_conf),
      .new_be   (tr_new_be)
   );

   stp_slot_pick #(.TAG_W(TAG_W), .CONF_W(CONF_W)) i_lk_pick (
      .slot_tag  (lk_tag_v),
      .slot_conf (lk_conf_v),
      .key       (lk_tag),
      .pick      (lk_pick)
   );

   assign lk_core = core_e'(lk_be[BE_W-1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_valid <= 1'b0;
         pred_id    <= '0;
         pred_big   <= 1'b0;
      end else begin
         pred_valid <= lk_valid;
         if (lk_valid) begin
            pred_id  <= lk_id_v[lk_pick];
            pred_big <= (lk_core == CORE_BIG);
         end
      end
   end
endmodule

// File: rtl/stp_predictor_chk.sv
module stp_predictor_chk #(
   parameter int unsigned ID_W   = 9,
   parameter int unsigned CONF_W = 2,
   parameter int unsigned BE_W   = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   lk_valid,
   input logic                   pred_valid,
   input logic                   tr_valid,
   input logic [1:0][ID_W-1:0]   old_id,
   input logic [1:0][ID_W-1:0]   new_id,
   input logic [1:0][CONF_W-1:0] old_conf,
   input logic [1:0][CONF_W-1:0] new_conf,
   input logic [BE_W-1:0]        old_be,
   input logic [BE_W-1:0]        new_be
);
   localparam logic [BE_W-1:0] BE_MAX = {BE_W{1'b1}};

   a_r2_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> pred_valid);

   a_r2_quiet_next: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !pred_valid);

   // R7: one training step touches at most one candidate's confidence
   a_r7_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
      tr_valid |-> $countones({new_conf[1] != old_conf[1], new_conf[0] != old_conf[0]}) <= 1);

   for (genvar s = 0; s < 2; s++) begin : g_slot_chk
      a_r5_conf_step: assert property (@(posedge clk) disable iff (!rst_n)
         tr_valid && (new_id[s] == old_id[s]) && (new_conf[s] > old_conf[s])
         |-> new_conf[s] == old_conf[s] + CONF_W'(1));

      a_r6_fresh_conf: assert property (@(posedge clk) disable iff (!rst_n)
         tr_valid && (new_id[s] != old_id[s]) |-> new_conf[s] == CONF_W'(1));
   end

   a_r8_be_hold: assert property (@(posedge clk) disable iff (!rst_n)
      tr_valid && (new_be == old_be) |-> (old_be == '0) || (old_be == BE_MAX));

   a_r8_be_step: assert property (@(posedge clk) disable iff (!rst_n)
      tr_valid && (new_be != old_be)
      |-> (new_be == old_be + BE_W'(1)) || (new_be == old_be - BE_W'(1)));
endmodule

bind stp_predictor stp_predictor_chk #(.ID_W(ID_W), .CONF_W(CONF_W), .BE_W(BE_W)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .lk_valid   (lk_valid),
   .pred_valid (pred_valid),
   .tr_valid   (tr_valid),
   .old_id     (tr_old_id),
   .new_id     (tr_new_id),
   .old_conf   (tr_old_conf),
   .new_conf   (tr_new_conf),
   .old_be     (tr_old_be),
   .new_be     (tr_new_be)
);

// File: tb/test_stp_predictor.sv
module test_stp_predictor;
   localparam int unsigned ID_W  = 9;
   localparam int unsigned TAG_W = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             lk_valid = 1'b0;
   logic [ID_W-1:0]  lk_id = '0;
   logic [TAG_W-1:0] lk_tag = '0;
   logic             tr_valid = 1'b0;
   logic [ID_W-1:0]  tr_id = '0;
   logic [ID_W-1:0]  tr_succ_id = '0;
   logic [TAG_W-1:0] tr_succ_tag = '0;
   logic             tr_below = 1'b0;
   logic             pred_valid;
   logic [ID_W-1:0]  pred_id;
   logic             pred_big;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   stp_predictor i_stp_predictor (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_id(lk_id), .lk_tag(lk_tag),
      .tr_valid(tr_valid), .tr_id(tr_id), .tr_succ_id(tr_succ_id),
      .tr_succ_tag(tr_succ_tag), .tr_below(tr_below),
      .pred_valid(pred_valid), .pred_id(pred_id), .pred_big(pred_big)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic lookup(input string req, input int id, input int tag,
                         input int exp_id, input int exp_big);
      @(negedge clk);
      lk_valid = 1'b1; lk_id = ID_W'(id); lk_tag = TAG_W'(tag);
      @(negedge clk);
      lk_valid = 1'b0;
      chk("R2", "pred_valid", int'(pred_valid), 1);
      chk(req, "pred_id", int'(pred_id), exp_id);
      chk(req, "pred_big", int'(pred_big), exp_big);
   endtask

   task automatic train(input int id, input int succ, input int tag, input bit below);
      @(negedge clk);
      tr_valid = 1'b1; tr_id = ID_W'(id); tr_succ_id = ID_W'(succ);
      tr_succ_tag = TAG_W'(tag); tr_below = below;
      @(negedge clk);
      tr_valid = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "pred_valid after reset", int'(pred_valid), 0);
      chk("R1", "pred_big after reset", int'(pred_big), 0);
      chk("R1", "pred_id after reset", int'(pred_id), 0);
      lookup("R1", 5, 0, 0, 1);
      @(negedge clk);
      chk("R2", "pred_valid idle", int'(pred_valid), 0);
   endtask

   task automatic t_install();
      train(5, 'h1A3, 4, 1'b0);           // R6: empty slot 1 taken, be 3
      lookup("R3", 5, 4, 'h1A3, 1);
   endtask

   task automatic t_saturate();
      for (int k = 0; k < 3; k++) train(5, 'h1A3, 4, 1'b0);
      // R5: slot 1 must hold 3, not wrap to 0, so it wins on tag 7
      lookup("R5", 5, 7, 'h1A3, 1);
   endtask

   task automatic t_demote();
      train(5, 'h055, 2, 1'b1);           // R6: slot 0 (conf 0) replaced, be 2
      lookup("R6", 5, 2, 'h055, 1);
      train(5, 'h0AA, 6, 1'b1);           // R7: slot 0 demoted to 0, be 1
      lookup("R7", 5, 2, 'h055, 0);
      train(5, 'h0AA, 6, 1'b1);           // R6: slot 0 replaced, be 0
      lookup("R6", 5, 6, 'h0AA, 0);
      lookup("R4", 5, 2, 'h1A3, 0);        // no match: conf 3 beats 1
   endtask

   task automatic t_tie();
      train(20, 'h011, 1, 1'b0);          // tie victim is slot 1
      train(20, 'h022, 3, 1'b0);          // slot 0 filled
      lookup("R4", 20, 5, 'h022, 1);       // equal conf, slot 0 wins
      lookup("R3", 20, 1, 'h011, 1);
   endtask

   task automatic t_backend();
      bit seq [9] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
      int exp [9] = '{0, 0, 0, 0, 1, 1, 1, 1, 0};
      for (int k = 0; k < 9; k++) begin
         train(30, 0, 0, seq[k]);
         lookup("R8", 30, 0, 0, exp[k]);
      end
   endtask

   task automatic t_bypass();
      @(negedge clk);
      tr_valid = 1'b1; tr_id = ID_W'(40); tr_succ_id = ID_W'('h133);
      tr_succ_tag = TAG_W'(5); tr_below = 1'b1;
      lk_valid = 1'b1; lk_id = ID_W'(40); lk_tag = TAG_W'(5);
      @(negedge clk);
      tr_valid = 1'b0; lk_valid = 1'b0;
      chk("R9", "bypass pred_id", int'(pred_id), 'h133);
      chk("R9", "bypass pred_big", int'(pred_big), 0);
      lookup("R9", 40, 5, 'h133, 0);
   endtask

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_install();
      t_saturate();
      t_demote();
      t_tie();
      t_backend();
      t_bypass();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule